// File: doc/BRIEF.md
# Timed compare pulse generator

This peripheral drives one output pin at a chosen instant of a free-running 64-bit time counter. Software programs a 64-bit compare value through a 32-bit register bus. When the time counter reaches that value plus a fixed latency of two counter cycles, the block produces one output event. Depending on the selected edge mode, the event drives the pin high, drives it low or inverts it.

The compare value is written as two 32-bit words. The high word is written first and is held aside. The low-word write then commits both halves at once, so a half-written value can never match. A committed value of zero means "disarmed". Every committed nonzero value fires at most once.

An event counter increments on each event. Software reads it twice; if the count has not moved between the reads, a pulse was missed. Clearing the enable bit, or selecting input direction, freezes the pin and the counter.

Top module: `timed_compare_pulse`

## Requirements
- R1: After reset the pin is low and the control word, both compare halves and the event counter all read zero.
- R2: The control word lives at offset 0x00 and its fields are:
  - bit 0 is enable;
  - bit 1 is direction, with 0 meaning output;
  - bits 3:2 are the edge mode.

  Bits 31:4 read back as zero.
- R3: A write to offset 0x14 only loads a hidden high word. A write to offset 0x10 makes {hidden high word, written low word} the active compare value in a single step. Reads of 0x10 and 0x14 return the low and high halves of the active value.
- R4: While the active compare value is zero, no event is ever produced, whatever the time counter does.
- R5: An event fires on the clock edge at which the sampled time counter equals the active compare value plus 2. The pin shows the new level right after that edge.
- R6: In edge mode 0 an event drives the pin to 1.
- R7: In edge mode 1 an event drives the pin to 0.
- R8: In edge mode 2 an event inverts the pin.
- R9: Edge mode 3 is reserved. It produces no event, so the pin and the counter stay unchanged.
- R10: The event counter at offset 0x30 grows by exactly one per event, even when the event leaves the pin level unchanged.
- R11: With enable at 0, or with direction at 1, no event occurs: the pin holds its level and the counter does not move.
- R12: A committed nonzero compare value fires at most once. If the time counter later equals that value plus 2 again, nothing happens until a new low-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time counter is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W (8) | Register byte offset |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Read data for busAddr (combinational) |
| timeCount | input | 2*DATA_W (64) | Free-running time counter |
| pinOut | output | 1 | Generated output pin |

## Verification
The hardest situations to reach are the ones that need the time counter to return to a value it has already passed.

- A zero compare value matches only when the counter reads exactly 2.
- A fired compare value could only fire again if the counter came back to the same value.

The bench owns the time counter and can rewind it to any value between clock edges. This lets it sweep the counter through 2 while the block is disarmed, and back over an already-fired target, with the pin and the event counter watched throughout. The bench also writes a lone high word and checks the readback before the low word commits it.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE   = 2'd0,
    EDGE_FALL   = 2'd1,
    EDGE_TOGGLE = 2'd2,
    EDGE_RSVD   = 2'd3
  } edge_mode_e;

  // strobes from register decode to the datapath
  typedef struct packed {
    logic loadHigh;
    logic commit;
  } cmp_strobe_t;

  localparam int unsigned OFS_CTRL   = 32'h00;
  localparam int unsigned OFS_CMP_LO = 32'h10;
  localparam int unsigned OFS_CMP_HI = 32'h14;
  localparam int unsigned OFS_EVCNT  = 32'h30;

  localparam int unsigned CTRL_BITS = 4;

endpackage

// File: rtl/cpg_regs.sv
module cpg_regs
  import cpg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic [2*DATA_W-1:0]   activeCmp,
  input  logic [CNT_W-1:0]      eventCount,
  output logic                  ctrlEn,
  output logic                  ctrlDir,
  output edge_mode_e            ctrlMode,
  output cmp_strobe_t           strobe,
  output logic [DATA_W-1:0]     cmpWord,
  output logic [DATA_W-1:0]     busRdData
);

  logic selCtrl;
  logic selLo;
  logic selHi;
  logic selCnt;

  assign selCtrl = (busAddr == ADDR_W'(OFS_CTRL));
  assign selLo   = (busAddr == ADDR_W'(OFS_CMP_LO));
  assign selHi   = (busAddr == ADDR_W'(OFS_CMP_HI));
  assign selCnt  = (busAddr == ADDR_W'(OFS_EVCNT));

  assign strobe.loadHigh = busWr && selHi;
  assign strobe.commit   = busWr && selLo;
  assign cmpWord         = busWrData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlEn   <= 1'b0;
      ctrlDir  <= 1'b0;
      ctrlMode <= EDGE_RISE;
    end else if (busWr && selCtrl) begin
      ctrlEn   <= busWrData[0];
      ctrlDir  <= busWrData[1];
      ctrlMode <= edge_mode_e'(busWrData[3:2]);
    end
  end

  always_comb begin
    busRdData = '0;
    if (selCtrl) begin
      busRdData = DATA_W'({ctrlMode, ctrlDir, ctrlEn});
    end else if (selLo) begin
      busRdData = activeCmp[DATA_W-1:0];
    end else if (selHi) begin
      busRdData = activeCmp[2*DATA_W-1:DATA_W];
    end else if (selCnt) begin
      busRdData = DATA_W'(eventCount);
    end
  end

endmodule

// File: rtl/cpg_datapath.sv
module cpg_datapath
  import cpg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int LATENCY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cmp_strobe_t           strobe,
  input  logic [DATA_W-1:0]     cmpWord,
  input  logic [2*DATA_W-1:0]   timeCount,
  input  logic                  ctrlEn,
  input  logic                  ctrlDir,
  input  edge_mode_e            ctrlMode,
  output logic [2*DATA_W-1:0]   activeCmp,
  output logic [CNT_W-1:0]      eventCount,
  output logic                  pinOut,
  output logic                  fireNow
);

  localparam int CMP_W = 2 * DATA_W;

  logic [DATA_W-1:0] shadowHigh;
  logic [CMP_W-1:0]  stagedCmp;
  logic [CMP_W-1:0]  matchTime;
  logic              armed;
  logic              timeHit;
  logic              modeValid;
  logic              pinNext;

  assign stagedCmp = {shadowHigh, cmpWord};
  assign matchTime = activeCmp + CMP_W'(LATENCY);
  assign timeHit   = (matchTime == timeCount);
  assign modeValid = (ctrlMode != EDGE_RSVD);
  assign fireNow   = armed && ctrlEn && !ctrlDir && modeValid && timeHit;

  // high half is staged, low-word write commits both halves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowHigh <= '0;
      activeCmp  <= '0;
    end else begin
      if (strobe.loadHigh) shadowHigh <= cmpWord;
      if (strobe.commit)   activeCmp  <= stagedCmp;
    end
  end

  // one shot per commit; a zero commit leaves the block disarmed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (strobe.commit) begin
      armed <= (stagedCmp != '0);
    end else if (fireNow) begin
      armed <= 1'b0;
    end
  end

  always_comb begin
    unique case (ctrlMode)
      EDGE_RISE:   pinNext = 1'b1;
      EDGE_FALL:   pinNext = 1'b0;
      EDGE_TOGGLE: pinNext = !pinOut;
      default:     pinNext = pinOut;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinOut     <= 1'b0;
      eventCount <= '0;
    end else if (fireNow) begin
      pinOut     <= pinNext;
      eventCount <= eventCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/timed_compare_pulse.sv
module timed_compare_pulse
  import cpg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int LATENCY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [2*DATA_W-1:0]   timeCount,
  output logic                  pinOut
);

  logic                ctrlEn;
  logic                ctrlDir;
  edge_mode_e          ctrlMode;
  cmp_strobe_t         strobe;
  logic [DATA_W-1:0]   cmpWord;
  logic [2*DATA_W-1:0] activeCmp;
  logic [CNT_W-1:0]    eventCount;
  logic                fireNow;

  cpg_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .activeCmp  (activeCmp),
    .eventCount (eventCount),
    .ctrlEn     (ctrlEn),
    .ctrlDir    (ctrlDir),
    .ctrlMode   (ctrlMode),
    .strobe     (strobe),
    .cmpWord    (cmpWord),
    .busRdData  (busRdData)
  );

  cpg_datapath #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .LATENCY (LATENCY)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cmpWord    (cmpWord),
    .timeCount  (timeCount),
    .ctrlEn     (ctrlEn),
    .ctrlDir    (ctrlDir),
    .ctrlMode   (ctrlMode),
    .activeCmp  (activeCmp),
    .eventCount (eventCount),
    .pinOut     (pinOut),
    .fireNow    (fireNow)
  );

endmodule

// File: rtl/cpg_checker.sv
module cpg_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                pinOut,
  input logic                ctrlEn,
  input logic [1:0]          ctrlMode,
  input logic                fireNow,
  input logic [2*DATA_W-1:0] activeCmp,
  input logic [CNT_W-1:0]    eventCount
);

  assert_commit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWr && busAddr == ADDR_W'(8'h10)) |=> $stable(activeCmp));

  assert_zero_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (activeCmp == '0) |=> $stable(eventCount));

  assert_rise_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fireNow && ctrlMode == 2'd0) |=> pinOut);

  assert_fall_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fireNow && ctrlMode == 2'd1) |=> !pinOut);

  assert_toggle_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fireNow && ctrlMode == 2'd2) |=> (pinOut != $past(pinOut)));

  assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlMode == 2'd3) |=> ($stable(eventCount) && $stable(pinOut)));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fireNow |=> (eventCount == $past(eventCount) + CNT_W'(1)));

  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fireNow |=> $stable(eventCount));

  assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEn |=> ($stable(pinOut) && $stable(eventCount)));

endmodule

bind timed_compare_pulse cpg_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .pinOut     (pinOut),
  .ctrlEn     (ctrlEn),
  .ctrlMode   (ctrlMode),
  .fireNow    (fireNow),
  .activeCmp  (activeCmp),
  .eventCount (eventCount)
);

// File: tb/timed_compare_pulse_tb.sv
module timed_compare_pulse_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_LO   = 8'h10;
  localparam logic [7:0] A_HI   = 8'h14;
  localparam logic [7:0] A_CNT  = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h30;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] timeCount = 64'h0000_0001_FFFF_FFC0;
  logic        pinOut;

  int          loadSeq = 0;
  int          seenSeq = 0;
  logic [63:0] loadVal = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] stamp;
    logic        level;
  } evt_t;
  evt_t expQ[$];

  logic        modelPin = 1'b0;
  logic [31:0] modelCnt = '0;
  logic        prevPin = 1'b0;

  timed_compare_pulse u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .timeCount (timeCount),
    .pinOut    (pinOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // free-running time source, rewindable from the stimulus
  always @(negedge clk) begin
    if (loadSeq != seenSeq) begin
      timeCount <= loadVal;
      seenSeq   <= loadSeq;
    end else begin
      timeCount <= timeCount + 64'd1;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every pin change must match the head of the scoreboard
  always @(negedge clk) begin
    evt_t e;
    if (rst_n && pinOut !== prevPin) begin
      if (expQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R4/R9/R11/R12 unexpected pin change: actual %b at count %h expected no change",
                 pinOut, timeCount);
      end else begin
        e = expQ.pop_front();
        check("R5 event time", timeCount, e.stamp);
        check("R6/R7/R8 pin level", 64'(pinOut), 64'(e.level));
      end
    end
    prevPin = pinOut;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1;
    busAddr = a;
    busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
    busAddr = A_CNT;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic progCmp(logic [63:0] c);
    wr(A_HI, c[63:32]);
    wr(A_LO, c[31:0]);
  endtask

  task automatic runTo(logic [63:0] t);
    while (timeCount < t) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic rewind(logic [63:0] v);
    @(posedge clk);
    #1;
    loadVal = v;
    loadSeq++;
    @(negedge clk);
    #1;
  endtask

  // driver: predict the event, push it, then program it
  task automatic stepEvent(logic [1:0] mode, output logic [63:0] c);
    evt_t e;
    logic lvl;
    c = timeCount + 64'd24;
    case (mode)
      2'd0:    lvl = 1'b1;
      2'd1:    lvl = 1'b0;
      default: lvl = ~modelPin;
    endcase
    if (lvl != modelPin) begin
      e.stamp = c + 64'd2;
      e.level = lvl;
      expQ.push_back(e);
    end
    modelPin = lvl;
    modelCnt = modelCnt + 32'd1;
    progCmp(c);
    runTo(c + 64'd2);
  endtask

  task automatic quietWindow(string req);
    logic [63:0] c;
    logic [31:0] d;
    c = timeCount + 64'd24;
    progCmp(c);
    runTo(c + 64'd4);
    rd(A_CNT, d);
    check({req, " counter held"}, 64'(d), 64'(modelCnt));
    check({req, " pin held"}, 64'(pinOut), 64'(modelPin));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] c;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 pin", 64'(pinOut), 64'd0);
    rd(A_CTRL, d); check("R1 ctrl", 64'(d), 64'd0);
    rd(A_LO, d);   check("R1 cmp low", 64'(d), 64'd0);
    rd(A_HI, d);   check("R1 cmp high", 64'(d), 64'd0);
    rd(A_CNT, d);  check("R1 count", 64'(d), 64'd0);

    // R2: control fields; upper bits read zero (toggle mode, enabled, active still zero)
    wr(A_CTRL, 32'hFFFF_FFF9);
    rd(A_CTRL, d); check("R2 ctrl readback", 64'(d), 64'h9);

    // R6 rising, twice (R10: second leaves pin high but still counts)
    wr(A_CTRL, 32'h1);
    stepEvent(2'd0, c);
    rd(A_CNT, d); check("R10 count after rise", 64'(d), 64'(modelCnt));
    check("R6 pin high", 64'(pinOut), 64'd1);
    stepEvent(2'd0, c);
    rd(A_CNT, d); check("R10 count without pin change", 64'(d), 64'(modelCnt));

    // R7 falling
    wr(A_CTRL, 32'h5);
    stepEvent(2'd1, c);
    check("R7 pin low", 64'(pinOut), 64'd0);

    // R8 toggle twice
    wr(A_CTRL, 32'h9);
    stepEvent(2'd2, c);
    check("R8 pin after first toggle", 64'(pinOut), 64'd1);
    stepEvent(2'd2, c);
    check("R8 pin after second toggle", 64'(pinOut), 64'd0);
    rd(A_CNT, d); check("R10 count after toggles", 64'(d), 64'(modelCnt));
    check("R5 scoreboard drained", 64'(expQ.size()), 64'd0);

    // R3: staging of the high word
    wr(A_HI, 32'hABCD_0123);
    rd(A_HI, d); check("R3 high unchanged before commit", 64'(d), 64'(c[63:32]));
    rd(A_LO, d); check("R3 low unchanged before commit", 64'(d), 64'(c[31:0]));
    wr(A_LO, 32'h5555_0000);
    rd(A_HI, d); check("R3 high after commit", 64'(d), 64'hABCD_0123);
    rd(A_LO, d); check("R3 low after commit", 64'(d), 64'h5555_0000);

    // R4: zero disarms even when the counter sweeps through 2
    progCmp(64'd0);
    rd(A_LO, d); check("R4 active low zero", 64'(d), 64'd0);
    rewind(64'hFFFF_FFFF_FFFF_FFF0);
    runTo(64'hFFFF_FFFF_FFFF_FFFC);
    rewind(64'd0);
    runTo(64'd12);
    rd(A_CNT, d); check("R4 counter held", 64'(d), 64'(modelCnt));
    check("R4 pin held", 64'(pinOut), 64'(modelPin));
    rewind(64'h0000_0002_0000_0100);

    // R9 reserved mode
    wr(A_CTRL, 32'hD);
    quietWindow("R9");

    // R11 disabled, then input direction
    wr(A_CTRL, 32'h8);
    quietWindow("R11 disabled");
    wr(A_CTRL, 32'hB);
    quietWindow("R11 input direction");

    // R12 one shot per commit
    wr(A_CTRL, 32'h9);
    stepEvent(2'd2, c);
    check("R12 first fire", 64'(pinOut), 64'(modelPin));
    rewind(c - 64'd10);
    runTo(c + 64'd6);
    rd(A_CNT, d); check("R12 no second fire", 64'(d), 64'(modelCnt));
    check("R12 pin held", 64'(pinOut), 64'(modelPin));
    check("R5 scoreboard empty at end", 64'(expQ.size()), 64'd0);

    finishRun();
  end

endmodule